// File: doc/BRIEF.md
# Shared-Ramp Wilkinson Conversion Controller

This block is the digital half of a Wilkinson analog-to-digital converter that serves many input channels with a single voltage ramp. A start pulse launches a conversion run. The block raises a ramp-enable line for the external ramp generator and clears a binary counter that advances once per clock. Each channel has its own comparator, which switches when the common ramp crosses that channel's stored voltage. When a channel's comparator switches, the block captures the counter value as that channel's code. One counter therefore digitises every channel in the same run. The run length is 2^N clock cycles, where N is a resolution setting between 8 and 12 bits.

A run handles a single quantity class, either charges or times, and a select input chooses the class. The select is captured at start and reported next to the codes, so the next stage can store the results correctly. A full memory column takes two runs, one for each class. Comparator lines are asynchronous to the conversion clock, so each line passes through a two-stage synchronizer. Only the first rising edge that a channel shows during a run is used. A channel whose comparator never rises during the run reads as full scale. One cycle after the counter reaches the top of the selected range, the block emits a single done pulse. The codes then hold until the next run starts.

Top module: `wilk_conv_ctrl`

## Requirements
- R1: After reset, ramp_en_o and done_o are 0, kind_o is 0 and every code in codes_o is 0.
- R2: A start_i pulse seen while idle raises ramp_en_o at the next clock edge and clears every code to 0 at that same edge. ramp_en_o then stays high for exactly 2^N cycles, one cycle for each counter value from 0 to 2^N-1.
- R3: N is the unsigned value of res_i, clamped to the range 8 to 12. Values below 8 give 8 bits, values above 12 give 12 bits, and the top counter value is 2^N-1.
- R4: done_o is high for exactly one cycle. It rises at the clock edge that follows the cycle in which the counter holds 2^N-1, and ramp_en_o falls at that same edge.
- R5: Call the edge that raises ramp_en_o edge 0. If a comparator line rises between edge m and edge m+1, that channel's code is m+2. The offset of 2 is the latency of the synchronizer plus the edge detector. Each channel's code sits at bits [i*12 +: 12] of codes_o, and channels do not affect one another.
- R6: Only the first synchronized rising edge of a channel in a run sets its code. Later falls and rises of that comparator leave the code unchanged.
- R7: A channel that shows no rising edge during the run gets the code 2^N-1. This includes a line that was already high before the start.
- R8: A start_i pulse while a run is in progress is ignored. The run length and the done timing do not change.
- R9: kind_o takes the value of kind_i (0 = charge, 1 = time) at the accepted start. It holds that value through the run and afterwards, even if kind_i changes.
- R10: Once a run ends, codes_o stays unchanged until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Pulse that starts a run while idle |
| res_i | input | 4 | Requested resolution in bits (clamped to 8..12) |
| kind_i | input | 1 | Quantity class for the run: 0 charge, 1 time |
| cmp_i | input | 36 | Per-channel comparator outputs, asynchronous |
| ramp_en_o | output | 1 | Enables the shared ramp during a run |
| kind_o | output | 1 | Quantity class captured at start |
| codes_o | output | 432 | 36 packed 12-bit channel codes |
| done_o | output | 1 | One-cycle pulse marking the end of a run |

## Verification
On every cycle, the assertions check the following. The done pulse lasts one cycle and follows a cycle with the ramp enabled. The ramp falls only together with done. Codes read zero when the ramp rises. The class tag holds while the ramp runs. Codes stay frozen while the block is idle with no start. A start during a run never drops the ramp without a done. Only the bench scenarios can show the values themselves: the exact run length for each resolution setting, including the clamped settings; the code offset of m+2 relative to the comparator flip; first-edge-only capture when a comparator bounces; full scale for silent or already-high channels; and the separation between the 36 lanes.

// File: rtl/wcc_pkg.sv
package wcc_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } wcc_state_e;

    // Clamp a requested bit count into the supported window.
    function automatic int wcc_clamp_bits(input int req, input int lo, input int hi);
        if (req < lo) return lo;
        if (req > hi) return hi;
        return req;
    endfunction

endpackage

// File: rtl/wcc_sync.sv
module wcc_sync #(
    parameter int NCH = 36
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] cmp_i,
    output logic [NCH-1:0] rise_o
);

    typedef struct packed {
        logic [NCH-1:0] s1;
        logic [NCH-1:0] s2;
        logic [NCH-1:0] prev;
    } sync_t;

    sync_t d, q;

    always_comb begin
        d      = q;
        d.s1   = cmp_i;
        d.s2   = q.s1;
        d.prev = q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // Rising edge of the synchronized comparator level.
    assign rise_o = q.s2 & ~q.prev;

endmodule

// File: rtl/wcc_seq.sv
module wcc_seq
    import wcc_pkg::*;
#(
    parameter int MAX_BITS = 12,
    parameter int MIN_BITS = 8,
    parameter int RES_W    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [RES_W-1:0]    res_i,
    input  logic                kind_i,
    output logic                run_o,
    output logic                clear_o,
    output logic                end_o,
    output logic                done_o,
    output logic                kind_o,
    output logic [MAX_BITS-1:0] cnt_o
);

    typedef struct packed {
        wcc_state_e          state;
        logic [MAX_BITS-1:0] cnt;
        logic [MAX_BITS-1:0] limit;
        logic                done;
        logic                kind;
    } seq_t;

    seq_t d, q;
    int                  bits;
    logic [MAX_BITS-1:0] lim_new;
    logic                accept;
    logic                at_end;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        bits   = wcc_clamp_bits(int'(res_i), MIN_BITS, MAX_BITS);
        for (int b = 0; b < MAX_BITS; b++) begin
            lim_new[b] = (b < bits);
        end
        accept = (q.state == ST_IDLE) && start_i;
        at_end = (q.state == ST_RUN) && (q.cnt == q.limit);
        if (accept) begin
            d.state = ST_RUN;
            d.cnt   = '0;
            d.limit = lim_new;
            d.kind  = kind_i;
        end else if (at_end) begin
            d.state = ST_IDLE;
            d.done  = 1'b1;
        end else if (q.state == ST_RUN) begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign run_o   = (q.state == ST_RUN);
    assign clear_o = accept;
    assign end_o   = at_end;
    assign done_o  = q.done;
    assign kind_o  = q.kind;
    assign cnt_o   = q.cnt;

endmodule

// File: rtl/wcc_lanes.sv
module wcc_lanes #(
    parameter int NCH = 36,
    parameter int W   = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             run_i,
    input  logic             end_i,
    input  logic [W-1:0]     cnt_i,
    input  logic [NCH-1:0]   rise_i,
    output logic [NCH*W-1:0] codes_o
);

    typedef struct packed {
        logic [W-1:0] code;
        logic         got;
    } lane_t;

    for (genvar g = 0; g < NCH; g++) begin : g_lane
        lane_t d, q;

        always_comb begin
            d = q;
            if (clear_i) begin
                d.code = '0;
                d.got  = 1'b0;
            end else if (run_i && !q.got && (rise_i[g] || end_i)) begin
                // On the final count the counter already holds full scale.
                d.code = cnt_i;
                d.got  = 1'b1;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= d;
        end

        assign codes_o[g*W +: W] = q.code;
    end

endmodule

// File: rtl/wilk_conv_ctrl.sv
module wilk_conv_ctrl #(
    parameter  int NCH      = 36,
    parameter  int MAX_BITS = 12,
    parameter  int MIN_BITS = 8,
    localparam int RES_W    = $clog2(MAX_BITS + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic [RES_W-1:0]        res_i,
    input  logic                    kind_i,
    input  logic [NCH-1:0]          cmp_i,
    output logic                    ramp_en_o,
    output logic                    kind_o,
    output logic [NCH*MAX_BITS-1:0] codes_o,
    output logic                    done_o
);

    logic                run;
    logic                clear;
    logic                last;
    logic [MAX_BITS-1:0] cnt;
    logic [NCH-1:0]      rise;

    wcc_sync #(.NCH(NCH)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmp_i  (cmp_i),
        .rise_o (rise)
    );

    wcc_seq #(.MAX_BITS(MAX_BITS), .MIN_BITS(MIN_BITS), .RES_W(RES_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .res_i   (res_i),
        .kind_i  (kind_i),
        .run_o   (run),
        .clear_o (clear),
        .end_o   (last),
        .done_o  (done_o),
        .kind_o  (kind_o),
        .cnt_o   (cnt)
    );

    wcc_lanes #(.NCH(NCH), .W(MAX_BITS)) u_lanes (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear),
        .run_i   (run),
        .end_i   (last),
        .cnt_i   (cnt),
        .rise_i  (rise),
        .codes_o (codes_o)
    );

    assign ramp_en_o = run;

endmodule

// File: rtl/wcc_checker.sv
module wcc_checker #(
    parameter int NCH      = 36,
    parameter int MAX_BITS = 12
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    start_i,
    input logic                    ramp_en_o,
    input logic                    kind_o,
    input logic [NCH*MAX_BITS-1:0] codes_o,
    input logic                    done_o
);

    a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r4_ramp_falls_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ramp_en_o) |-> done_o);

    a_r4_done_after_run: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(ramp_en_o));

    a_r2_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ramp_en_o) |-> (codes_o == '0));

    a_r9_kind_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_en_o |=> $stable(kind_o));

    a_r10_codes_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ramp_en_o && !start_i) |=> $stable(codes_o));

    a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (ramp_en_o && start_i) |=> (ramp_en_o || done_o));

endmodule

bind wilk_conv_ctrl wcc_checker #(.NCH(NCH), .MAX_BITS(MAX_BITS)) u_wcc_checker (.*);

// File: tb/wilk_conv_ctrl_bench.sv
`timescale 1ns/1ps
module wilk_conv_ctrl_bench;

    localparam int NCH = 36;
    localparam int W   = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [3:0]        res_i = 4'd8;
    logic              kind_i = 1'b0;
    logic [NCH-1:0]    cmp_i = '0;
    logic              ramp_en_o;
    logic              kind_o;
    logic [NCH*W-1:0]  codes_o;
    logic              done_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    int plan[NCH];
    int drop_at[NCH];
    int rerise_at[NCH];
    bit pre_high[NCH];

    always #5 clk = ~clk;

    wilk_conv_ctrl u_wilk_conv_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .res_i     (res_i),
        .kind_i    (kind_i),
        .cmp_i     (cmp_i),
        .ramp_en_o (ramp_en_o),
        .kind_o    (kind_o),
        .codes_o   (codes_o),
        .done_o    (done_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int code_of(input int ch);
        return int'(codes_o[ch*W +: W]);
    endfunction

    task automatic clear_plan();
        for (int ch = 0; ch < NCH; ch++) begin
            plan[ch] = -1; drop_at[ch] = -1; rerise_at[ch] = -1; pre_high[ch] = 0;
        end
    endtask

    // One conversion run with comparator flips modelled as delays from the ramp start.
    task automatic run_conv(input int res, input bit kind, input int start_poke,
                            input int kind_flip, input string tag);
        int nb;
        int lim;
        int viol;
        int nz;
        int exp;
        nb = (res < 8) ? 8 : ((res > 12) ? 12 : res);
        lim = (1 << nb) - 1;
        viol = 0;
        nz = 0;
        @(negedge clk);
        for (int ch = 0; ch < NCH; ch++) if (pre_high[ch]) cmp_i[ch] = 1'b1;
        repeat (4) @(negedge clk);
        res_i = 4'(res); kind_i = kind; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check({"R2 ramp raised ", tag}, int'(ramp_en_o), 1);
        for (int ch = 0; ch < NCH; ch++) if (code_of(ch) != 0) nz++;
        check({"R2 codes cleared ", tag}, nz, 0);
        for (int k = 0; k <= lim + 1; k++) begin
            if (k > 0) @(negedge clk);
            if (k == lim + 1) begin
                check({"R4 done after top count ", tag}, int'(done_o), 1);
                check({"R4 ramp dropped ", tag}, int'(ramp_en_o), 0);
            end else if (done_o || !ramp_en_o) begin
                viol++;
            end
            for (int ch = 0; ch < NCH; ch++) begin
                if (plan[ch] >= 2 && plan[ch] - 2 == k) cmp_i[ch] = 1'b1;
                if (drop_at[ch] == k) cmp_i[ch] = 1'b0;
                if (rerise_at[ch] == k) cmp_i[ch] = 1'b1;
            end
            start_i = (k == start_poke);
            if (k == kind_flip) kind_i = ~kind_i;
        end
        check({"R2 R3 R8 ramp length ", tag}, viol, 0);
        @(negedge clk);
        check({"R4 done single cycle ", tag}, int'(done_o), 0);
        check({"R9 kind captured ", tag}, int'(kind_o), int'(kind));
        for (int ch = 0; ch < NCH; ch++) begin
            exp = (plan[ch] >= 0) ? plan[ch] : lim;
            if (drop_at[ch] >= 0)
                check($sformatf("R6 ch%0d %s", ch, tag), code_of(ch), exp);
            else if (plan[ch] < 0)
                check($sformatf("R7 ch%0d %s", ch, tag), code_of(ch), exp);
            else
                check($sformatf("R5 ch%0d %s", ch, tag), code_of(ch), exp);
        end
        cmp_i = '0;
        kind_i = ~kind_i;
        repeat (6) @(negedge clk);
        exp = (plan[0] >= 0) ? plan[0] : lim;
        check({"R10 codes held while idle ", tag}, code_of(0), exp);
        check({"R9 kind held while idle ", tag}, int'(kind_o), int'(kind));
    endtask

    task automatic t_reset();
        int nz;
        nz = 0;
        for (int ch = 0; ch < NCH; ch++) if (code_of(ch) != 0) nz++;
        check("R1 ramp after reset", int'(ramp_en_o), 0);
        check("R1 done after reset", int'(done_o), 0);
        check("R1 kind after reset", int'(kind_o), 0);
        check("R1 codes after reset", nz, 0);
    endtask

    task automatic t_spread8();
        clear_plan();
        for (int ch = 0; ch < NCH; ch++) plan[ch] = (ch % 9 == 4) ? -1 : 3 + ch * 7;
        run_conv(8, 1'b0, -1, -1, "spread8");
    endtask

    task automatic t_full12();
        clear_plan();
        for (int ch = 0; ch < NCH; ch++) plan[ch] = 5 + ch * 113;
        plan[0] = 4095;
        plan[1] = 2;
        plan[2] = -1;
        run_conv(12, 1'b1, -1, -1, "full12");
    endtask

    task automatic t_mid10();
        clear_plan();
        for (int ch = 0; ch < NCH; ch++) plan[ch] = 2 + ch * 29;
        run_conv(10, 1'b1, 300, 400, "mid10 R8 R9");
    endtask

    task automatic t_clamp();
        clear_plan();
        for (int ch = 0; ch < NCH; ch++) plan[ch] = 250 - ch * 6;
        plan[3] = -1;
        run_conv(3, 1'b0, -1, -1, "R3 clamp low");
        clear_plan();
        for (int ch = 0; ch < NCH; ch++) plan[ch] = 4000 - ch * 97;
        plan[5] = -1;
        run_conv(15, 1'b0, -1, -1, "R3 clamp high");
    endtask

    task automatic t_bounce();
        clear_plan();
        for (int ch = 0; ch < NCH; ch++) plan[ch] = 10 + ch * 5;
        plan[3] = 40; drop_at[3] = 42; rerise_at[3] = 46;
        plan[9] = 20; drop_at[9] = 19; rerise_at[9] = 200;
        plan[7] = -1; pre_high[7] = 1;
        run_conv(8, 1'b1, -1, -1, "R6 bounce");
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R4 watchdog: actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        clear_plan();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_spread8();
        t_full12();
        t_mid10();
        t_clamp();
        t_bounce();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule